// File: doc/BRIEF.md
# Accumulator Zero-Test Flag Unit

This unit compares one of two 36-bit signed accumulators against zero and writes the result into the condition-code byte of a 16-bit status word. Each accumulator is made of a 4-bit extension, a 16-bit upper word and a 16-bit lower word. The unit only reads the accumulators and never changes them. The subtraction of zero exists only to produce flags.

On a clock edge where the execute strobe is high, the unit takes the current status word from its input. It copies the mode byte (bits 15..8) unchanged and builds a new flag byte. The new flags are sign, zero, extension-in-use and unnormalized. It also updates two sticky flags: size and limit. Overflow and carry are cleared. The result is held in a register until the next strobe. A flag from the accompanying data-move path reports that limiting occurred, and that flag feeds the sticky limit bit.

Top module: `tstcc_unit`

## Requirements
- R1: While rst_n is low and on the first edge after it, sr_o is 16'h0000.
- R2: On an edge where exec_i is low, sr_o keeps its value whatever the other inputs do.
- R3: On an edge where exec_i is high, sr_o[15:8] takes sr_i[15:8] unchanged.
- R4: src_sel_i = 0 tests acc_a_i and src_sel_i = 1 tests acc_b_i. The other accumulator has no effect on the flags.
- R5: After a strobe, sr_o[3] (sign) equals bit 35 of the tested accumulator.
- R6: After a strobe, sr_o[2] (zero) is 1 exactly when all 36 bits of the tested accumulator are 0.
- R7: After a strobe, sr_o[1] and sr_o[0] (overflow, carry) are 0.
- R8: After a strobe, sr_o[5] (extension in use) is 1 when bits 35..31 of the tested accumulator are not all equal.
- R9: After a strobe, sr_o[4] (unnormalized) is 1 when bit 31 equals bit 30 of the tested accumulator.
- R10: After a strobe, sr_o[7] (size, sticky) equals sr_i[7] OR (bit 30 XOR bit 29 of the tested accumulator).
- R11: After a strobe, sr_o[6] (limit, sticky) equals sr_i[6] OR limit_i.
- R12: Testing an accumulator of 36'h8_0203_0000 with sr_i = 16'h0300 gives sr_o = 16'h0338.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_i | input | 1 | Execute strobe; loads a new status word |
| src_sel_i | input | 1 | Accumulator select: 0 = A, 1 = B |
| acc_a_i | input | 36 | Accumulator A (extension, upper word, lower word) |
| acc_b_i | input | 36 | Accumulator B |
| limit_i | input | 1 | Limiting occurred on the parallel data move |
| sr_i | input | 16 | Current status word |
| sr_o | output | 16 | Updated status word |

## Verification
The hardest cases involve bits 35..29, because extension-in-use, unnormalized and size each depend on a different pair or run of those bits, and the flags interact only when they are combined. The stimulus covers all 128 patterns of those seven bits. For each pattern it sets the lower 29 bits either to zero or to a nonzero value, so the zero flag is reached only when all seven upper bits are also zero. Every pattern is crossed with both select values, all four incoming sticky states and both limit values. The unselected accumulator always holds the inverted pattern, so a wrong select shows up in the flags.

// File: rtl/tstcc_pkg.sv
// Package: shared widths and flag-byte bit positions for the zero-test unit.
// Assumes: the flag byte is the low byte of a 16-bit status word.
package tstcc_pkg;
    localparam int SR_W = 16;
    localparam int CCR_W = 8;

    // Bit positions inside the flag byte; neighbouring logic decodes these.
    localparam int BIT_SZ = 7;
    localparam int BIT_L = 6;
    localparam int BIT_E = 5;
    localparam int BIT_U = 4;
    localparam int BIT_N = 3;
    localparam int BIT_Z = 2;
    localparam int BIT_V = 1;
    localparam int BIT_C = 0;

    typedef struct packed {
        logic size_f;
        logic limit_f;
        logic ext_f;
        logic unnorm_f;
        logic neg_f;
        logic zero_f;
        logic ovf_f;
        logic carry_f;
    } ccr_t;
endpackage

// File: rtl/tstcc_src_mux.sv
// Module: tstcc_src_mux
// Picks the accumulator under test. Assumes both inputs are the same width.
module tstcc_src_mux #(
    parameter int ACC_W = 36
) (
    input  logic             sel_i,
    input  logic [ACC_W-1:0] a_i,
    input  logic [ACC_W-1:0] b_i,
    output logic [ACC_W-1:0] acc_o
);
    // Purpose: route A when sel is 0, B when sel is 1.
    always_comb begin
        acc_o = sel_i ? b_i : a_i;
    end
endmodule

// File: rtl/tstcc_flag_eval.sv
// Module: tstcc_flag_eval
// Derives the new flag byte from the tested value, the incoming sticky bits
// and the data-move limit flag. Assumes ACC_W > EXT_W + 2.
module tstcc_flag_eval
    import tstcc_pkg::*;
#(
    parameter int ACC_W = 36,
    parameter int EXT_W = 4
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic             sz_prev_i,
    input  logic             l_prev_i,
    input  logic             limit_i,
    output ccr_t             ccr_o
);
    localparam int TOP = ACC_W - 1;
    localparam int MSW_TOP = TOP - EXT_W;  // top bit of the upper word
    localparam int RUN_W = EXT_W + 1;      // extension plus the upper-word sign

    logic [RUN_W-1:0] sign_run;

    // Purpose: collect the extension bits together with the upper-word sign bit.
    always_comb begin
        sign_run = acc_i[TOP:MSW_TOP];
    end

    // Purpose: form each flag of the result byte.
    always_comb begin
        ccr_o.size_f = sz_prev_i | (acc_i[MSW_TOP-1] ^ acc_i[MSW_TOP-2]);
        ccr_o.limit_f = l_prev_i | limit_i;
        ccr_o.ext_f = ~((&sign_run) | ~(|sign_run));
        ccr_o.unnorm_f = ~(acc_i[MSW_TOP] ^ acc_i[MSW_TOP-1]);
        ccr_o.neg_f = acc_i[TOP];
        ccr_o.zero_f = ~(|acc_i);
        ccr_o.ovf_f = 1'b0;
        ccr_o.carry_f = 1'b0;
    end
endmodule

// File: rtl/tstcc_unit.sv
// Module: tstcc_unit (top)
// Tests a selected accumulator against zero and registers the updated status
// word on each execute strobe. The mode byte passes through unchanged.
// Assumes: the caller supplies the current status word on sr_i.
module tstcc_unit
    import tstcc_pkg::*;
#(
    parameter int ACC_W = 36,
    parameter int EXT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exec_i,
    input  logic             src_sel_i,
    input  logic [ACC_W-1:0] acc_a_i,
    input  logic [ACC_W-1:0] acc_b_i,
    input  logic             limit_i,
    input  logic [SR_W-1:0]  sr_i,
    output logic [SR_W-1:0]  sr_o
);
    logic [ACC_W-1:0] tested;
    ccr_t             new_ccr;
    logic [SR_W-1:0]  sr_q;

    tstcc_src_mux #(.ACC_W(ACC_W)) u_mux (
        .sel_i (src_sel_i),
        .a_i   (acc_a_i),
        .b_i   (acc_b_i),
        .acc_o (tested)
    );

    tstcc_flag_eval #(.ACC_W(ACC_W), .EXT_W(EXT_W)) u_eval (
        .acc_i     (tested),
        .sz_prev_i (sr_i[BIT_SZ]),
        .l_prev_i  (sr_i[BIT_L]),
        .limit_i   (limit_i),
        .ccr_o     (new_ccr)
    );

    // Purpose: status register; loads on strobe, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (exec_i) begin
            sr_q <= {sr_i[SR_W-1:CCR_W], new_ccr};
        end
    end

    assign sr_o = sr_q;
endmodule

// File: rtl/tstcc_checker.sv
// Module: tstcc_checker
// Port-level properties of tstcc_unit, attached with bind.
module tstcc_checker #(
    parameter int ACC_W = 36
) (
    input logic             clk,
    input logic             rst_n,
    input logic             exec_i,
    input logic             src_sel_i,
    input logic [ACC_W-1:0] acc_a_i,
    input logic [ACC_W-1:0] acc_b_i,
    input logic             limit_i,
    input logic [15:0]      sr_i,
    input logic [15:0]      sr_o
);
    logic [ACC_W-1:0] chosen;
    assign chosen = src_sel_i ? acc_b_i : acc_a_i;

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> $stable(sr_o));

    p_mode_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i |=> sr_o[15:8] == $past(sr_i[15:8]));

    p_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i |=> sr_o[3] == $past(chosen[ACC_W-1]));

    p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && chosen == '0) |=> sr_o[2]);

    p_vc_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i |=> sr_o[1:0] == 2'b00);

    p_limit_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && (limit_i || sr_i[6])) |=> sr_o[6]);
endmodule

bind tstcc_unit tstcc_checker #(.ACC_W(ACC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec_i    (exec_i),
    .src_sel_i (src_sel_i),
    .acc_a_i   (acc_a_i),
    .acc_b_i   (acc_b_i),
    .limit_i   (limit_i),
    .sr_i      (sr_i),
    .sr_o      (sr_o)
);

// File: tb/tstcc_unit_tb_top.sv
// Bench: sweeps bits 35..29 exhaustively against select, sticky and limit inputs.
module tstcc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_i = 1'b0;
    logic        src_sel_i = 1'b0;
    logic [35:0] acc_a_i = '0;
    logic [35:0] acc_b_i = '0;
    logic        limit_i = 1'b0;
    logic [15:0] sr_i = '0;
    logic [15:0] sr_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tstcc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .src_sel_i(src_sel_i),
        .acc_a_i(acc_a_i), .acc_b_i(acc_b_i), .limit_i(limit_i),
        .sr_i(sr_i), .sr_o(sr_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic [35:0] v, input logic [15:0] s, input logic lim);
        logic [7:0] f;
        f[7] = s[7] | (v[30] != v[29]);
        f[6] = s[6] | lim;
        f[5] = !(v[35:31] == 5'b00000 || v[35:31] == 5'b11111);
        f[4] = (v[31] == v[30]);
        f[3] = v[35];
        f[2] = (v == 36'd0);
        f[1] = 1'b0;
        f[0] = 1'b0;
        return {s[15:8], f};
    endfunction

    initial begin
        logic [35:0] v;
        logic [15:0] e;
        logic [15:0] held;
        @(negedge clk);
        check("R1", sr_o, 16'h0000);
        rst_n = 1'b1;
        // R12 worked example
        acc_a_i = 36'h8_0203_0000; acc_b_i = 36'h0; src_sel_i = 0; sr_i = 16'h0300; exec_i = 1;
        @(negedge clk);
        exec_i = 0;
        check("R12", sr_o, 16'h0338);
        // Main sweep (R4..R11, R3)
        for (int top = 0; top < 128; top++) begin
            for (int lo = 0; lo < 2; lo++) begin
                for (int sel = 0; sel < 2; sel++) begin
                    for (int st = 0; st < 4; st++) begin
                        for (int lim = 0; lim < 2; lim++) begin
                            v = {top[6:0], (lo == 1) ? 29'h0ABC_1235 : 29'h0};
                            src_sel_i = sel[0];
                            acc_a_i = sel[0] ? ~v : v;
                            acc_b_i = sel[0] ? v : ~v;
                            sr_i = {8'h80 ^ top[7:0], st[1:0], 6'h2B ^ top[5:0]};
                            limit_i = lim[0];
                            exec_i = 1;
                            e = model(v, sr_i, lim[0]);
                            @(negedge clk);
                            exec_i = 0;
                            check("R3", {sr_o[15:8], 8'h00}, {e[15:8], 8'h00});
                            check("R4 R5 R6", {13'h0, sr_o[5], sr_o[3:2]}, {13'h0, e[5], e[3:2]});
                            check("R7", {14'h0, sr_o[1:0]}, 16'h0000);
                            check("R8 R9", {14'h0, sr_o[5:4]}, {14'h0, e[5:4]});
                            check("R10 R11", {14'h0, sr_o[7:6]}, {14'h0, e[7:6]});
                        end
                    end
                end
            end
        end
        // R2: strobe low, inputs change, output holds
        held = sr_o;
        for (int k = 0; k < 16; k++) begin
            acc_a_i = {k[3:0], 32'h0}; acc_b_i = ~acc_a_i; src_sel_i = k[0];
            sr_i = {k[3:0], 12'hFFF}; limit_i = k[1];
            @(negedge clk);
            check("R2", sr_o, held);
        end
        // R6 zero with nonzero other accumulator
        acc_a_i = '1; acc_b_i = '0; src_sel_i = 1; sr_i = 16'h0000; limit_i = 0; exec_i = 1;
        @(negedge clk);
        exec_i = 0;
        check("R6", sr_o, 16'h0014);
        // R1 reset again
        rst_n = 0;
        @(negedge clk);
        check("R1", sr_o, 16'h0000);
        rst_n = 1;
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule